// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Request Control

This block is the digital front end of a synthesizer loop. It samples two pulse trains on the system clock: one from the reference divider and one from the feedback divider. A rising edge on the reference input raises a pump-up request. A rising edge on the feedback input raises a pump-down request. Each request stays high until the other one arrives. When both requests are high, they are held together for a fixed number of clock cycles and then cleared in the same cycle. This forced overlap guarantees that the pump always sees a short pulse, so the detector has no dead zone around lock.

A polarity input swaps the two requests, so the loop can drive an oscillator whose frequency falls as its tuning voltage rises. A high-impedance indicator is high whenever no request is active. A pump current code is registered and passed on to the pump. The parameter `CUR_LEVELS` selects one of two current variants. With 16 levels, the full 4-bit code is used. With 2 levels, only one select bit is used, and it chooses between the lowest step and the eighth step.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it goes high, `pump_up` and `pump_dn` are low, `pump_hiz` is high and `cur_set` is 0.
- R2: A 0-to-1 change of `ref_pulse` between two clock samples sets the reference request one cycle later. A 0-to-1 change of `fb_pulse` sets the feedback request the same way. A set request stays high while the other request is absent.
- R3: Once both requests are high, both stay high for exactly `MIN_OVL` cycles (default 3). They then fall in the same cycle.
- R4: `pump_hiz` is 1 exactly when both `pump_up` and `pump_dn` are 0.
- R5: With `pol_inv` = 0, the reference request drives `pump_up` and the feedback request drives `pump_dn`. With `pol_inv` = 1 they are swapped, and the swap takes effect in the same cycle, without a register.
- R6: With `CUR_LEVELS` = 16, `cur_set` equals the `cur_code` sampled at the previous clock edge. Code k stands for (k+1) steps of 100 µA.
- R7: With `CUR_LEVELS` = 2, `cur_set` is registered from bit 0 of `cur_code`. Bit 0 = 0 gives code 0 (100 µA) and bit 0 = 1 gives code 7 (800 µA). The other bits are ignored.
- R8: Only rising edges count. A held-high input gives one request. Edges that arrive while both requests are high are ignored, and this includes the clearing cycle.
- R9: Edges on both inputs in the same sample set both requests together. This gives a single overlap pulse of `MIN_OVL` cycles and no one-sided pulse, which is the locked case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Reference divider output |
| fb_pulse | input | 1 | Feedback divider output |
| pol_inv | input | 1 | 1 swaps the up and down requests |
| cur_code | input | CW | Requested pump current code |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| pump_hiz | output | 1 | High when no request is active |
| cur_set | output | CW | Registered current setting |

## Verification
An input edge sampled at clock edge k shows up on the request outputs after edge k, one register stage. The overlap clears at edge k+`MIN_OVL` after both requests are high. `cur_set` follows `cur_code` one edge later. The polarity swap and `pump_hiz` follow the register state within the same cycle. The bench changes its inputs only just after a falling edge. A behavioural model advances on each rising edge from the inputs held since then. All outputs are compared with the model at every falling edge, so every result is sampled half a cycle after the edge that produced it.

// File: rtl/pfd_cp_pkg.sv
package pfd_cp_pkg;
   typedef struct packed {
      logic ref_req;
      logic fb_req;
   } pfd_req_t;

   localparam int unsigned STEP_LOW  = 0;
   localparam int unsigned STEP_HIGH = 7;
endpackage

// File: rtl/pfd_rise_det.sv
module pfd_rise_det #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sig_in,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[i] <= 1'b0;
         else        prev_q[i] <= sig_in[i];
      end
      assign rise[i] = sig_in[i] & ~prev_q[i];
   end
endmodule

// File: rtl/pfd_req_ctrl.sv
module pfd_req_ctrl
   import pfd_cp_pkg::*;
#(
   parameter int unsigned MIN_OVL = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ref_edge,
   input  logic     fb_edge,
   output pfd_req_t req
);
   localparam int unsigned CNT_W = (MIN_OVL > 1) ? $clog2(MIN_OVL) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_OVL - 1);

   pfd_req_t         req_q;
   logic [CNT_W-1:0] ovl_q;
   logic             both;

   assign both = req_q.ref_req & req_q.fb_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         ovl_q <= '0;
      end else if (both) begin
         if (ovl_q == LAST) begin
            req_q <= '0;
            ovl_q <= '0;
         end else begin
            ovl_q <= ovl_q + 1'b1;
         end
      end else begin
         req_q.ref_req <= req_q.ref_req | ref_edge;
         req_q.fb_req  <= req_q.fb_req  | fb_edge;
      end
   end

   assign req = req_q;
endmodule

// File: rtl/pfd_cur_map.sv
module pfd_cur_map
   import pfd_cp_pkg::*;
#(
   parameter int unsigned CUR_LEVELS = 16,
   parameter int unsigned CW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] code_in,
   output logic [CW-1:0] code_out
);
   logic [CW-1:0] mapped;

   if (CUR_LEVELS == 2) begin : g_two
      assign mapped = code_in[0] ? CW'(STEP_HIGH) : CW'(STEP_LOW);
   end else begin : g_full
      assign mapped = code_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_out <= '0;
      else        code_out <= mapped;
   end
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl
   import pfd_cp_pkg::*;
#(
   parameter int unsigned MIN_OVL    = 3,
   parameter int unsigned CUR_LEVELS = 16,
   parameter int unsigned CW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_pulse,
   input  logic          fb_pulse,
   input  logic          pol_inv,
   input  logic [CW-1:0] cur_code,
   output logic          pump_up,
   output logic          pump_dn,
   output logic          pump_hiz,
   output logic [CW-1:0] cur_set
);
   if (MIN_OVL < 1) begin : g_bad_ovl
      $error("MIN_OVL must be at least 1");
   end
   if (CUR_LEVELS != 2 && CUR_LEVELS != 16) begin : g_bad_lvl
      $error("CUR_LEVELS must be 2 or 16");
   end
   if (CW < 4) begin : g_bad_cw
      $error("CW must be at least 4");
   end

   logic [1:0] edges;
   pfd_req_t   req;

   pfd_rise_det #(.W(2)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in ({ref_pulse, fb_pulse}),
      .rise   (edges)
   );

   pfd_req_ctrl #(.MIN_OVL(MIN_OVL)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_edge (edges[1]),
      .fb_edge  (edges[0]),
      .req      (req)
   );

   pfd_cur_map #(.CUR_LEVELS(CUR_LEVELS), .CW(CW)) u_cur (
      .clk      (clk),
      .rst_n    (rst_n),
      .code_in  (cur_code),
      .code_out (cur_set)
   );

   assign pump_up  = pol_inv ? req.fb_req  : req.ref_req;
   assign pump_dn  = pol_inv ? req.ref_req : req.fb_req;
   assign pump_hiz = ~(req.ref_req | req.fb_req);
endmodule

// File: rtl/pfd_cp_ctrl_chk.sv
module pfd_cp_ctrl_chk #(
   parameter int unsigned MIN_OVL    = 3,
   parameter int unsigned CUR_LEVELS = 16,
   parameter int unsigned CW         = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ref_pulse,
   input logic          fb_pulse,
   input logic          pol_inv,
   input logic [CW-1:0] cur_code,
   input logic          pump_up,
   input logic          pump_dn,
   input logic          pump_hiz,
   input logic [CW-1:0] cur_set
);
   localparam int unsigned KW = $clog2(MIN_OVL + 2);

   logic          both;
   logic [KW-1:0] run_q;

   assign both = pump_up & pump_dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (both) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   // R3: the overlap never lasts longer than MIN_OVL cycles
   p_ovl_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      both |-> (run_q < KW'(MIN_OVL)));

   // R3: the overlap ends only after exactly MIN_OVL cycles
   p_ovl_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!both && $past(both)) |-> ($past(run_q) == KW'(MIN_OVL - 1)));

   // R3: both requests fall in the same cycle
   p_fall_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pump_up) && $stable(pol_inv)) |-> $fell(pump_dn));

   // R2, R5: a rising up request with pol_inv = 0 needs a reference sample
   p_up_from_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pump_up) && !pol_inv && $stable(pol_inv)) |-> $past(ref_pulse));

   // R5: with pol_inv = 1 the down request comes from the reference
   p_dn_from_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pump_dn) && pol_inv && $stable(pol_inv)) |-> $past(ref_pulse));

   if (CUR_LEVELS == 16) begin : g_cur16
      // R6: the current code passes through with one register stage
      p_cur_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (cur_set == $past(cur_code)));
   end else begin : g_cur2
      // R7: only the two allowed settings appear
      p_cur_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (cur_set == ($past(cur_code[0]) ? CW'(7) : CW'(0))));
   end
endmodule

bind pfd_cp_ctrl pfd_cp_ctrl_chk #(
   .MIN_OVL(MIN_OVL), .CUR_LEVELS(CUR_LEVELS), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
   .pol_inv(pol_inv), .cur_code(cur_code), .pump_up(pump_up),
   .pump_dn(pump_dn), .pump_hiz(pump_hiz), .cur_set(cur_set)
);

// File: tb/pfd_cp_ctrl_test.sv
module pfd_cp_ctrl_test;
   localparam int MIN_OVL = 3;
   localparam int CW      = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_pulse = 1'b0;
   logic          fb_pulse = 1'b0;
   logic          pol_inv = 1'b0;
   logic [CW-1:0] cur_code = '0;
   logic          pump_up, pump_dn, pump_hiz;
   logic [CW-1:0] cur_set;
   logic          up2, dn2, hiz2;
   logic [CW-1:0] cur_set2;

   int checks = 0;
   int fails  = 0;
   string tag = "R1";

   // model state
   bit m_ref, m_fb, m_pr, m_pf;
   int m_cnt;
   int m_cur, m_cur2;

   always #4 clk = ~clk;

   pfd_cp_ctrl #(.MIN_OVL(MIN_OVL), .CUR_LEVELS(16), .CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
      .pol_inv(pol_inv), .cur_code(cur_code), .pump_up(pump_up),
      .pump_dn(pump_dn), .pump_hiz(pump_hiz), .cur_set(cur_set));

   pfd_cp_ctrl #(.MIN_OVL(MIN_OVL), .CUR_LEVELS(2), .CW(CW)) uut_two (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
      .pol_inv(pol_inv), .cur_code(cur_code), .pump_up(up2),
      .pump_dn(dn2), .pump_hiz(hiz2), .cur_set(cur_set2));

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ref = 0; m_fb = 0; m_pr = 0; m_pf = 0; m_cnt = 0;
         m_cur = 0; m_cur2 = 0;
      end else begin
         bit re, fe;
         re = ref_pulse && !m_pr;
         fe = fb_pulse && !m_pf;
         m_pr = ref_pulse;
         m_pf = fb_pulse;
         if (m_ref && m_fb) begin
            if (m_cnt == MIN_OVL - 1) begin
               m_ref = 0; m_fb = 0; m_cnt = 0;
            end else m_cnt++;
         end else begin
            m_ref = m_ref | re;
            m_fb  = m_fb | fe;
         end
         m_cur  = int'(cur_code);
         m_cur2 = cur_code[0] ? 7 : 0;
      end
   end

   task automatic chk(string t, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit eu, ed;
      eu = pol_inv ? m_fb : m_ref;
      ed = pol_inv ? m_ref : m_fb;
      chk((tag == "R8" || tag == "R9" || tag == "R1") ? tag : (pol_inv ? "R5" : tag),
          int'(pump_up), int'(eu), "pump_up");
      chk(tag, int'(pump_dn), int'(ed), "pump_dn");
      chk("R4", int'(pump_hiz), int'(!m_ref && !m_fb), "pump_hiz");
      chk((tag == "R1") ? "R1" : "R6", int'(cur_set), m_cur, "cur_set");
      chk("R7", int'(cur_set2), m_cur2, "cur_set two-level");
   endtask

   // one cycle: compare at the falling edge, then drive new inputs
   task automatic cyc(bit r, bit f);
      @(negedge clk);
      compare();
      ref_pulse = r;
      fb_pulse  = f;
      cur_code  = cur_code + 4'd5;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0);
   endtask

   initial begin
      #200000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      tag = "R1";
      repeat (3) begin
         @(negedge clk);
         compare();
      end
      rst_n = 1'b1;
      idle(2);

      // R2: reference first, feedback later, then R3 overlap
      tag = "R2";
      cyc(1, 0); cyc(0, 0); idle(3);
      tag = "R3";
      cyc(0, 1); cyc(0, 0); idle(6);

      // R2: feedback first
      tag = "R2";
      cyc(0, 1); cyc(0, 0); idle(4);
      tag = "R3";
      cyc(1, 0); cyc(0, 0); idle(6);

      // R9: simultaneous edges
      tag = "R9";
      cyc(1, 1); cyc(0, 0); idle(6);
      cyc(1, 1); cyc(1, 1); cyc(1, 1); cyc(0, 0); idle(6);

      // R8: held level gives one request; edges during overlap are ignored
      tag = "R8";
      for (int i = 0; i < 10; i++) cyc(1, 0);
      cyc(0, 0); idle(2);
      cyc(0, 1); cyc(1, 0); cyc(0, 1); cyc(1, 0); cyc(0, 1);
      idle(8);
      cyc(1, 0); cyc(0, 1); cyc(0, 0); cyc(0, 0); cyc(1, 1); cyc(0, 0); idle(6);

      // R5: inverted polarity, including a swap while a request is pending
      tag = "R2";
      @(negedge clk); pol_inv = 1'b1;
      cyc(1, 0); cyc(0, 0); idle(2);
      @(negedge clk); compare(); pol_inv = 1'b0;
      idle(1);
      @(negedge clk); compare(); pol_inv = 1'b1;
      cyc(0, 1); idle(6);
      cyc(0, 1); cyc(0, 0); idle(2); cyc(1, 0); idle(6);
      @(negedge clk); pol_inv = 1'b0;

      // R6/R7: sweep every current code
      tag = "R2";
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         compare();
         cur_code = 4'(k);
      end
      idle(3);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule